// File: doc/BRIEF.md
# Zoned Data-Memory Wait-State Controller

This block sits between a processor core and its data-memory space, which is addressed with 14 bits. It decodes every core access into one of three places.

- The on-chip RAM window finishes in the cycle it is requested.
- The control-register window is flagged so that neighbouring logic can serve it, and it also finishes at once.
- The external range is served through a select line, read and write strobes, and the data lanes of a shared 24-bit bus. The core is held off for a number of wait cycles that depends on which of three external zones the address falls in.

The wait counts live in a 16-bit control register. That register holds five 3-bit fields and has its own write and read port. Only the three lowest fields steer the timing. The two upper fields are storage only. Every field comes out of reset at its largest value, so slow devices are safe before software has tuned the timing.

The core holds `dm_req` with a stable address, direction and write data until it sees `dm_ready`. In the cycle after `dm_ready` it either drops the request or presents a new one. An external access latches its address, direction, data and wait count in its first cycle. The register can therefore be rewritten in the middle of an access without disturbing that access.

Top module: `dmw_ctrl`

## Requirements
- R1: After reset, `wscfg_rdata` reads 0x7FFF: each of the five 3-bit fields holds 7, and bit 15 reads 0. While no request is present, `dm_ready`, `ext_sel`, `ext_rd` and `ext_wr` are low.
- R2: A request to 0x3000–0x37FF raises `ram_sel` and `dm_ready` in the same cycle. `ext_sel` stays low.
- R3: A request to 0x3800–0x3FFF raises `regwin_sel` and `dm_ready` in the same cycle. `ext_sel` stays low.
- R4: External zones are decoded as follows. 0x0000–0x03FF takes its count from field bits [2:0]. 0x0400–0x07FF takes its count from bits [5:3]. 0x0800–0x2FFF takes its count from bits [8:6].
- R5: For an external access with count N:
  - `ext_sel`, plus `ext_rd` for a read or `ext_wr` for a write, is high for exactly N+1 cycles, starting in the cycle the request is first seen.
  - `dm_ready` is low for the first N of those cycles and high on the last one.
  - `ext_rd` and `ext_wr` are never high together.
  - All strobes are low in the following cycle once the request is removed.
- R6: Bits [11:9] and [14:12] store and read back whatever is written to them, and they never change the length of any access.
- R7: A register write counts for accesses that start in a later cycle. It does not change the length of an access already in progress.
- R8: During an external write, `dm_wdata` is driven on bus bits [23:8]. During an external read, `dm_rdata` returns bus bits [23:8]. Bits [7:0] are never driven.
- R9: `ext_addr` equals the requested address and holds steady for the whole external access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dm_req | input | 1 | Core access request, held until ready |
| dm_addr | input | 14 | Data-memory word address |
| dm_write | input | 1 | 1 = write, 0 = read |
| dm_wdata | input | 16 | Write data from core |
| dm_rdata | output | 16 | Read data to core (bus bits 23:8) |
| dm_ready | output | 1 | Access completes this cycle |
| ram_sel | output | 1 | Internal RAM window access |
| regwin_sel | output | 1 | Control-register window access |
| ext_sel | output | 1 | External data-memory select |
| ext_rd | output | 1 | External read strobe / output enable |
| ext_wr | output | 1 | External write strobe |
| ext_addr | output | 14 | External address, held during access |
| ext_data | inout | 24 | Shared external bus; data on 23:8 |
| wscfg_we | input | 1 | Wait-state register write enable |
| wscfg_wdata | input | 16 | Wait-state register write value |
| wscfg_rdata | output | 16 | Wait-state register read value |

## Verification
The main function is exercised with several kinds of access.

- Directed addresses sit on every region edge (0x03FF/0x0400, 0x07FF/0x0800, 0x2FFF/0x3000, 0x37FF/0x3800, 0x3FFF). These separate a correct decode from an off-by-one bound.
- Register values put a different count in each zone. These separate a wrong field choice from a right one.
- Counts of 0 and 7 expose a counter that starts or ends one cycle off.
- Values that change only the two unused fields show that those fields never leak into timing.
- A register write issued in the middle of an access tells apart a design that samples the count once from one that reads it live.

Random addresses, directions and register values, drawn from a fixed seed, then cover the mixes in between.

// File: rtl/dmw_pkg.sv
package dmw_pkg;

  typedef enum logic [1:0] {
    RGN_EXT = 2'd0,
    RGN_RAM = 2'd1,
    RGN_REG = 2'd2
  } region_e;

  // Region classification: everything below the RAM base is external,
  // the register window starts at reg_lo and runs to the top of space.
  function automatic region_e classify(input int unsigned a,
                                       input int unsigned ram_lo,
                                       input int unsigned reg_lo);
    if (a >= reg_lo)      return RGN_REG;
    else if (a >= ram_lo) return RGN_RAM;
    else                  return RGN_EXT;
  endfunction

  // External zone index from two ascending zone bases.
  function automatic int unsigned zone_of(input int unsigned a,
                                          input int unsigned z1_lo,
                                          input int unsigned z2_lo);
    if (a >= z2_lo)      return 2;
    else if (a >= z1_lo) return 1;
    else                 return 0;
  endfunction

  // Wait cycles still owed after the first cycle of an access.
  function automatic int unsigned waits_after_first(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

endpackage

// File: rtl/dmw_decode.sv
module dmw_decode
  import dmw_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int NUM_ZONES = 3,
  parameter int RAM_LO    = 'h3000,
  parameter int REG_LO    = 'h3800,
  parameter int Z1_LO     = 'h0400,
  parameter int Z2_LO     = 'h0800,
  localparam int ZIDX_W   = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [ZIDX_W-1:0] zone
);

  always_comb begin
    region = classify(int'(addr), RAM_LO, REG_LO);
    zone   = ZIDX_W'(zone_of(int'(addr), Z1_LO, Z2_LO));
  end

endmodule

// File: rtl/dmw_wscfg.sv
module dmw_wscfg #(
  parameter int REG_W      = 16,
  parameter int WS_W       = 3,
  parameter int NUM_FIELDS = 5,
  parameter int NUM_ZONES  = 3,
  parameter int RST_WS     = 7,
  localparam int FIELD_BITS = NUM_FIELDS * WS_W,
  localparam int ZIDX_W     = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic [ZIDX_W-1:0] zone,
  output logic [WS_W-1:0]   ws_sel
);

  logic [WS_W-1:0]       field_q [NUM_FIELDS];
  logic [FIELD_BITS-1:0] packed_q;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  field_q[f] <= WS_W'(RST_WS);
      else if (we) field_q[f] <= wdata[f*WS_W +: WS_W];
    end
    assign packed_q[f*WS_W +: WS_W] = field_q[f];
  end

  if (FIELD_BITS < REG_W) begin : g_pad
    assign rdata = {{(REG_W-FIELD_BITS){1'b0}}, packed_q};
  end else begin : g_nopad
    assign rdata = packed_q[REG_W-1:0];
  end

  // Only the zone fields are ever selected; spare fields are storage only.
  always_comb begin
    ws_sel = field_q[0];
    for (int z = 0; z < NUM_ZONES; z++)
      if (zone == ZIDX_W'(z)) ws_sel = field_q[z];
  end

  // Fields change only on a write strobe.
  assert_field_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(rdata));

endmodule

// File: rtl/dmw_waitgen.sv
module dmw_waitgen
  import dmw_pkg::*;
#(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [WS_W-1:0] ws_n,
  output logic            busy,
  output logic [WS_W-1:0] cnt,
  output logic            last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (start && ws_n != '0) begin
      busy <= 1'b1;
      cnt  <= WS_W'(waits_after_first(int'(ws_n)));
    end
  end

  assign last = busy && (cnt == '0);

  // A started access with waits enters the wait phase with one fewer left.
  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && ws_n != '0) |=> (busy && cnt == $past(ws_n) - 1'b1));

  // The wait phase counts down by exactly one per cycle.
  assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1));

  // The last wait cycle always ends the wait phase.
  assert_last_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy);

endmodule

// File: rtl/dmw_ctrl.sv
module dmw_ctrl
  import dmw_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int DATA_W     = 16,
  parameter int BUS_W      = 24,
  parameter int REG_W      = 16,
  parameter int WS_W       = 3,
  parameter int NUM_FIELDS = 5,
  parameter int NUM_ZONES  = 3,
  parameter int RST_WS     = 7,
  parameter int RAM_LO     = 'h3000,
  parameter int REG_LO     = 'h3800,
  parameter int Z1_LO      = 'h0400,
  parameter int Z2_LO      = 'h0800,
  localparam int LANE_LO   = BUS_W - DATA_W,
  localparam int ZIDX_W    = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dm_req,
  input  logic [ADDR_W-1:0] dm_addr,
  input  logic              dm_write,
  input  logic [DATA_W-1:0] dm_wdata,
  output logic [DATA_W-1:0] dm_rdata,
  output logic              dm_ready,
  output logic              ram_sel,
  output logic              regwin_sel,
  output logic              ext_sel,
  output logic              ext_rd,
  output logic              ext_wr,
  output logic [ADDR_W-1:0] ext_addr,
  inout  wire  [BUS_W-1:0]  ext_data,
  input  logic              wscfg_we,
  input  logic [REG_W-1:0]  wscfg_wdata,
  output logic [REG_W-1:0]  wscfg_rdata
);

  region_e           region;
  logic [ZIDX_W-1:0] zone;
  logic [WS_W-1:0]   ws_sel;
  logic              busy, last;
  logic [WS_W-1:0]   cnt;

  // Named events for the assertions.
  logic              new_req, ext_start, first_done;
  logic              hold_write;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_wdata;
  logic              dir_write;
  logic [DATA_W-1:0] drive_val;

  dmw_decode #(
    .ADDR_W(ADDR_W), .NUM_ZONES(NUM_ZONES),
    .RAM_LO(RAM_LO), .REG_LO(REG_LO), .Z1_LO(Z1_LO), .Z2_LO(Z2_LO)
  ) u_decode (
    .addr(dm_addr), .region(region), .zone(zone)
  );

  dmw_wscfg #(
    .REG_W(REG_W), .WS_W(WS_W), .NUM_FIELDS(NUM_FIELDS),
    .NUM_ZONES(NUM_ZONES), .RST_WS(RST_WS)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(wscfg_we), .wdata(wscfg_wdata),
    .rdata(wscfg_rdata), .zone(zone), .ws_sel(ws_sel)
  );

  assign new_req    = dm_req && !busy;
  assign ext_start  = new_req && (region == RGN_EXT);
  assign first_done = ext_start && (ws_sel == '0);

  dmw_waitgen #(.WS_W(WS_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .start(ext_start), .ws_n(ws_sel),
    .busy(busy), .cnt(cnt), .last(last)
  );

  // Latch the access attributes at its first cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_addr  <= '0;
      hold_write <= 1'b0;
      hold_wdata <= '0;
    end else if (ext_start) begin
      hold_addr  <= dm_addr;
      hold_write <= dm_write;
      hold_wdata <= dm_wdata;
    end
  end

  always_comb begin
    ram_sel    = new_req && (region == RGN_RAM);
    regwin_sel = new_req && (region == RGN_REG);
    ext_sel    = ext_start || busy;
    dir_write  = busy ? hold_write : dm_write;
    ext_rd     = ext_sel && !dir_write;
    ext_wr     = ext_sel && dir_write;
    ext_addr   = busy ? hold_addr : dm_addr;
    drive_val  = busy ? hold_wdata : dm_wdata;
    dm_ready   = ram_sel || regwin_sel || first_done || last;
  end

  assign ext_data[BUS_W-1:LANE_LO] = ext_wr ? drive_val : {DATA_W{1'bz}};
  if (LANE_LO > 0) begin : g_low_lanes
    assign ext_data[LANE_LO-1:0] = {LANE_LO{1'bz}};
  end
  assign dm_rdata = ext_data[BUS_W-1:LANE_LO];

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_rd && ext_wr));

  assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_sel, regwin_sel, ext_sel}));

  assert_ram_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel |-> (dm_ready && !ext_sel));

  assert_regwin_fast_R3: assert property (@(posedge clk) disable iff (!rst_n)
    regwin_sel |-> (dm_ready && !ext_sel));

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel && !dm_ready) |=> (ext_sel && $stable(ext_addr)));

  assert_dir_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel && !dm_ready) |=> ($stable(ext_rd) && $stable(ext_wr)));

endmodule

// File: tb/dmw_ctrl_test.sv
`timescale 1ns/1ps
module dmw_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dm_req = 1'b0;
  logic [13:0] dm_addr = '0;
  logic        dm_write = 1'b0;
  logic [15:0] dm_wdata = '0;
  logic [15:0] dm_rdata;
  logic        dm_ready, ram_sel, regwin_sel, ext_sel, ext_rd, ext_wr;
  logic [13:0] ext_addr;
  wire  [23:0] bus;
  logic        wscfg_we = 1'b0;
  logic [15:0] wscfg_wdata = '0;
  logic [15:0] wscfg_rdata;

  int checks = 0;
  int errors = 0;
  logic [15:0] cfg_m;
  bit done = 0;

  always #2.5 clk = ~clk;

  dmw_ctrl uut (
    .clk(clk), .rst_n(rst_n), .dm_req(dm_req), .dm_addr(dm_addr),
    .dm_write(dm_write), .dm_wdata(dm_wdata), .dm_rdata(dm_rdata),
    .dm_ready(dm_ready), .ram_sel(ram_sel), .regwin_sel(regwin_sel),
    .ext_sel(ext_sel), .ext_rd(ext_rd), .ext_wr(ext_wr),
    .ext_addr(ext_addr), .ext_data(bus), .wscfg_we(wscfg_we),
    .wscfg_wdata(wscfg_wdata), .wscfg_rdata(wscfg_rdata)
  );

  // External device pattern returned on reads.
  function automatic logic [15:0] dev_pat(input logic [13:0] a);
    return {a[7:0] ^ 8'h3C, ~a[13:6]};
  endfunction

  assign bus[23:8] = ext_rd ? dev_pat(ext_addr) : 16'bz;

  // Expected waits: -2 register window, -1 RAM, else zone count.
  function automatic int exp_ws(input logic [13:0] a, input logic [15:0] c);
    int sh;
    if (a > 14'h37FF) return -2;
    if (a > 14'h2FFF) return -1;
    sh = (a < 14'h0400) ? 0 : (a < 14'h0800) ? 3 : 6;
    return int'((c >> sh) & 16'h7);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic cfg_write(input logic [15:0] v);
    @(negedge clk);
    wscfg_we = 1'b1; wscfg_wdata = v;
    @(negedge clk);
    wscfg_we = 1'b0;
    cfg_m = v & 16'h7FFF;
  endtask

  // One access; optional register write during wait cycle mid_at (>0).
  task automatic access(input logic [13:0] a, input bit w, input logic [15:0] d,
                        input int mid_at, input logic [15:0] mid_val, input string tag);
    int e, cyc;
    bit bad, mid_done;
    logic [15:0] rd;
    e = exp_ws(a, cfg_m);
    bad = 0; mid_done = 0; cyc = 0; rd = '0;
    @(negedge clk);
    dm_req = 1'b1; dm_addr = a; dm_write = w; dm_wdata = d;
    forever begin
      #1;
      if (e >= 0) begin
        if (!ext_sel || ext_rd == w || ext_wr != w || ext_addr != a || ram_sel || regwin_sel) bad = 1;
        if (w && bus[23:8] != d) bad = 1;
        rd = dm_rdata;
      end else if (e == -1) begin
        if (!ram_sel || ext_sel || regwin_sel) bad = 1;
      end else begin
        if (!regwin_sel || ext_sel || ram_sel) bad = 1;
      end
      if (dm_ready || cyc > 20) break;
      @(negedge clk);
      cyc++;
      if (mid_at > 0 && cyc == mid_at) begin
        wscfg_we = 1'b1; wscfg_wdata = mid_val; mid_done = 1;
      end else wscfg_we = 1'b0;
    end
    check(!bad, {tag, " strobes/select (R2 R3 R5 R9)"}, bad, 0);
    check(cyc == ((e < 0) ? 0 : e), {tag, " wait cycles (R4 R5)"}, cyc, (e < 0) ? 0 : e);
    if (e >= 0 && !w)
      check(rd == dev_pat(a), {tag, " read data (R8)"}, rd, dev_pat(a));
    @(negedge clk);
    dm_req = 1'b0; wscfg_we = 1'b0;
    if (mid_done) cfg_m = mid_val & 16'h7FFF;
    #1;
    check(!ext_sel && !ext_rd && !ext_wr && !dm_ready, {tag, " strobes drop (R5)"}, ext_sel, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cfg_m = 16'h7FFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check(wscfg_rdata == 16'h7FFF, "R1 reset register", wscfg_rdata, 16'h7FFF);
    check(!dm_ready && !ext_sel && !ext_rd && !ext_wr, "R1 idle outputs", dm_ready, 0);

    // R1/R5: default 7 waits in each zone
    access(14'h0000, 0, 16'h0, 0, 0, "R1 zone0 default");
    access(14'h0500, 1, 16'hBEEF, 0, 0, "R1 zone1 default");
    access(14'h2FFF, 0, 16'h0, 0, 0, "R1 zone2 default");

    // R2/R3 windows and edges
    access(14'h3000, 0, 16'h0, 0, 0, "R2 ram low");
    access(14'h37FF, 1, 16'h1234, 0, 0, "R2 ram high");
    access(14'h3800, 0, 16'h0, 0, 0, "R3 regwin low");
    access(14'h3FFF, 1, 16'h5555, 0, 0, "R3 regwin high");

    // R4 distinct counts per zone: z0=1, z1=4, z2=0
    cfg_write(16'h0021);
    check(wscfg_rdata == 16'h0021, "R4 readback", wscfg_rdata, 16'h0021);
    access(14'h03FF, 1, 16'hA5A5, 0, 0, "R4 z0 edge");
    access(14'h0400, 0, 16'h0, 0, 0, "R4 z1 low edge");
    access(14'h07FF, 1, 16'h0F0F, 0, 0, "R4 z1 high edge");
    access(14'h0800, 0, 16'h0, 0, 0, "R4 z2 zero wait");

    // R6 spare fields
    cfg_write(16'h01FF);
    access(14'h0100, 0, 16'h0, 0, 0, "R6 spare zero z0");
    cfg_write(16'hFE00);
    check(wscfg_rdata == 16'h7E00, "R6 spare readback bit15 zero", wscfg_rdata, 16'h7E00);
    access(14'h0100, 1, 16'hC3C3, 0, 0, "R6 spare full z0");
    access(14'h1000, 0, 16'h0, 0, 0, "R6 spare full z2");

    // R7 mid-access write: z0=5 then rewrite to 1 at wait cycle 2
    cfg_write(16'h0005);
    access(14'h0010, 0, 16'h0, 2, 16'h0001, "R7 in-flight unchanged");
    check(wscfg_rdata == 16'h0001, "R7 register updated", wscfg_rdata, 16'h0001);
    access(14'h0011, 1, 16'h7777, 0, 0, "R7 next access uses new");

    // Random mix
    void'($urandom(32'd1717));
    for (int i = 0; i < 200; i++) begin
      logic [13:0] a;
      if (i % 12 == 0) cfg_write(16'($urandom()));
      a = 14'($urandom());
      access(a, 1'($urandom()), 16'($urandom()), 0, 0, "R4 R5 R8 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule